// File: doc/BRIEF.md
# Control-Transfer Sequencer

This unit carries out the program-flow instructions of a small 8-bit processor with a 16-bit address space. The surrounding core hands it a decoded operation, a condition selector, the current zero and carry flags, a restart index, the address of the byte after the opcode, the stack pointer and the HL pair. The unit then runs the operation through a byte-wide memory port: it fetches operand bytes, writes the return address to the stack or reads it back, and computes the new program counter and stack pointer.

One sequence runs at a time. `busy` stays high from the cycle after the start until the last step, and `done` pulses once when the results on `pc_out` and `sp_out` are final. Internal cycles are spent only where the target core's timing needs them: on taken transfers, before a conditional return reads the stack, and after a return. A taken return-from-interrupt also raises `ie_pulse` together with `done` so that interrupts can be re-enabled.

Top module: `xfer_seq`

## Requirements
- R1: The condition selector `cond` is decoded as 0 = always, 1 = zero flag set, 2 = zero flag clear, 3 = carry flag set, 4 = carry flag clear. Codes 5 to 7 are never taken. Flags are sampled in the start cycle.
- R2: Absolute jump (op 0) reads the low byte at PC and then the high byte at PC+1, and forms the target as {high, low}. A taken jump lasts 3 busy cycles and loads the target. A not-taken jump lasts 2 and leaves PC at PC+2.
- R3: Relative jump (op 1) reads one byte at PC and, when taken, sets PC to PC+1 plus that byte as a signed value, over 2 busy cycles. When not taken it lasts 1 cycle and PC becomes PC+1.
- R4: A taken call (op 2) fetches a 16-bit target as in R2, spends one internal cycle, writes the return address (PC+2) high byte to SP-1 and then its low byte to SP-2, and ends with SP reduced by 2 and PC at the target, over 5 busy cycles. A not-taken call lasts 2 cycles and writes nothing.
- R5: Return (op 3) reads the low byte at SP and the high byte at SP+1, adds 2 to SP and spends one more internal cycle: 3 busy cycles. With a condition other than always, a test cycle comes first (4 cycles if taken). A not-taken return lasts 1 cycle and changes neither PC nor SP.
- R6: Return-from-interrupt (op 4) is always taken, whatever `cond` holds, behaves as an unconditional return, and asserts `ie_pulse` for one cycle together with `done`. No other operation asserts `ie_pulse`.
- R7: Restart (op 5) spends one internal cycle, pushes PC high and then low as in R4, and sets PC to `rst_idx` times 8, one of 0x00 to 0x38, over 3 busy cycles.
- R8: Jump to HL (op 6) loads PC from `hl_in` with no busy cycle, and `done` pulses in the next cycle.
- R9: While `mem_req` is high and `mem_ready` low, address, write enable and write data hold still, and the sequence waits. Every stalled cycle adds one busy cycle and does not change the results.
- R10: `start` is ignored while `busy` is high.
- R11: After reset `busy`, `done`, `ie_pulse` and `mem_req` are low. `done` is a one-cycle pulse in the cycle after the last busy cycle, and a memory write occurs only while busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence (taken only when idle) |
| op | input | 3 | Operation: 0 jump, 1 relative jump, 2 call, 3 return, 4 return-from-interrupt, 5 restart, 6 jump to HL, 7 none |
| cond | input | 3 | Condition selector (R1) |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| rst_idx | input | VSW | Restart vector index |
| pc_in | input | 2*DW | Address of the byte after the opcode |
| sp_in | input | 2*DW | Stack pointer at start |
| hl_in | input | 2*DW | HL pair |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| ie_pulse | output | 1 | Interrupt-enable pulse on return-from-interrupt |
| pc_out | output | 2*DW | Program counter |
| sp_out | output | 2*DW | Stack pointer |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 2*DW | Request address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with mem_ready |
| mem_ready | input | 1 | Request accepted this cycle |

## Verification
The assertions watch every cycle: a stalled request holds its address and data, every memory write happens while busy, `done` only appears when idle and always follows the fall of `busy`, and `ie_pulse` never appears without `done`. Only the bench scenarios can show the behaviour that depends on values: condition decoding, the exact busy-cycle counts of taken and not-taken forms, the signed relative offset, the order and placement of the stacked bytes, the eight restart vectors, and the fact that a second start during a sequence leaves the result alone.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

   typedef enum logic [2:0] {
      OP_JP   = 3'd0,
      OP_JR   = 3'd1,
      OP_CALL = 3'd2,
      OP_RET  = 3'd3,
      OP_RETI = 3'd4,
      OP_RST  = 3'd5,
      OP_JHL  = 3'd6,
      OP_NONE = 3'd7
   } xfer_op_e;

   localparam logic [2:0] CC_ALWAYS = 3'd0;
   localparam logic [2:0] CC_ZSET   = 3'd1;
   localparam logic [2:0] CC_ZCLR   = 3'd2;
   localparam logic [2:0] CC_CSET   = 3'd3;
   localparam logic [2:0] CC_CCLR   = 3'd4;

   typedef enum logic [3:0] {
      S_IDLE,
      S_IMM_LO,
      S_IMM_HI,
      S_SETTLE,
      S_PUSH_HI,
      S_PUSH_LO,
      S_TEST,
      S_POP_LO,
      S_POP_HI,
      S_TAIL
   } seq_st_e;

endpackage

// File: rtl/xfer_cond.sv
module xfer_cond
   import xfer_pkg::*;
(
   input  logic [2:0] cond,
   input  logic       flag_z,
   input  logic       flag_c,
   output logic       take
);
   always_comb begin
      case (cond)
         CC_ALWAYS: take = 1'b1;
         CC_ZSET:   take = flag_z;
         CC_ZCLR:   take = !flag_z;
         CC_CSET:   take = flag_c;
         CC_CCLR:   take = !flag_c;
         default:   take = 1'b0;
      endcase
   end
endmodule

// File: rtl/xfer_rel.sv
module xfer_rel #(
   parameter int DW = 8,
   localparam int AW = 2 * DW
) (
   input  logic [AW-1:0] base,
   input  logic [DW-1:0] offset,
   output logic [AW-1:0] sum
);
   logic [AW-1:0] ext;
   assign ext = {{(AW-DW){offset[DW-1]}}, offset};
   assign sum = base + ext;
endmodule

// File: rtl/xfer_vec.sv
module xfer_vec #(
   parameter int AW     = 16,
   parameter int VSW    = 3,
   parameter int STRIDE = 8,
   localparam int NVEC  = 1 << VSW
) (
   input  logic [VSW-1:0] idx,
   output logic [AW-1:0]  addr
);
   logic [AW-1:0] tbl [NVEC];

   for (genvar i = 0; i < NVEC; i++) begin : g_vec
      assign tbl[i] = AW'(i * STRIDE);
   end

   assign addr = tbl[idx];
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
   import xfer_pkg::*;
#(
   parameter int DW         = 8,
   parameter int VSW        = 3,
   parameter int VEC_STRIDE = 8,
   localparam int AW        = 2 * DW,
   localparam int NVEC      = 1 << VSW
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [2:0]     op,
   input  logic [2:0]     cond,
   input  logic           flag_z,
   input  logic           flag_c,
   input  logic [VSW-1:0] rst_idx,
   input  logic [AW-1:0]  pc_in,
   input  logic [AW-1:0]  sp_in,
   input  logic [AW-1:0]  hl_in,
   output logic           busy,
   output logic           done,
   output logic           ie_pulse,
   output logic [AW-1:0]  pc_out,
   output logic [AW-1:0]  sp_out,
   output logic           mem_req,
   output logic           mem_we,
   output logic [AW-1:0]  mem_addr,
   output logic [DW-1:0]  mem_wdata,
   input  logic [DW-1:0]  mem_rdata,
   input  logic           mem_ready
);

   if (DW < 4) begin : g_bad_dw
      $error("xfer_seq: DW must be at least 4");
   end
   if (VEC_STRIDE < 1 || (NVEC - 1) * VEC_STRIDE >= (1 << AW)) begin : g_bad_vec
      $error("xfer_seq: restart vectors do not fit the address space");
   end

   seq_st_e       state_q;
   xfer_op_e      op_q, op_e;
   logic          take_q, take_now;
   logic          done_q, ie_q;
   logic [AW-1:0] pc_q, sp_q, tgt_q;
   logic [AW-1:0] pc_inc, sp_inc, sp_dec, rel_sum, vec_addr;

   assign op_e   = xfer_op_e'(op);
   assign pc_inc = pc_q + AW'(1);
   assign sp_inc = sp_q + AW'(1);
   assign sp_dec = sp_q - AW'(1);

   xfer_cond u_cond (
      .cond   (cond),
      .flag_z (flag_z),
      .flag_c (flag_c),
      .take   (take_now)
   );

   xfer_rel #(.DW(DW)) u_rel (
      .base   (pc_inc),
      .offset (mem_rdata),
      .sum    (rel_sum)
   );

   xfer_vec #(.AW(AW), .VSW(VSW), .STRIDE(VEC_STRIDE)) u_vec (
      .idx  (rst_idx),
      .addr (vec_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         op_q    <= OP_NONE;
         take_q  <= 1'b0;
         done_q  <= 1'b0;
         ie_q    <= 1'b0;
         pc_q    <= '0;
         sp_q    <= '0;
         tgt_q   <= '0;
      end else begin
         done_q <= 1'b0;
         ie_q   <= 1'b0;
         case (state_q)
            S_IDLE: begin
               if (start && op_e != OP_NONE) begin
                  op_q   <= op_e;
                  pc_q   <= pc_in;
                  sp_q   <= sp_in;
                  take_q <= (op_e == OP_RETI) || take_now;
                  case (op_e)
                     OP_JP, OP_JR, OP_CALL: state_q <= S_IMM_LO;
                     OP_RET:  state_q <= (cond == CC_ALWAYS) ? S_POP_LO : S_TEST;
                     OP_RETI: state_q <= S_POP_LO;
                     OP_RST: begin
                        tgt_q   <= vec_addr;
                        state_q <= S_SETTLE;
                     end
                     default: begin
                        pc_q   <= hl_in;
                        done_q <= 1'b1;
                     end
                  endcase
               end
            end
            S_IMM_LO: begin
               if (mem_ready) begin
                  pc_q <= pc_inc;
                  if (op_q == OP_JR) begin
                     tgt_q   <= rel_sum;
                     state_q <= take_q ? S_SETTLE : S_IDLE;
                     done_q  <= !take_q;
                  end else begin
                     tgt_q[DW-1:0] <= mem_rdata;
                     state_q       <= S_IMM_HI;
                  end
               end
            end
            S_IMM_HI: begin
               if (mem_ready) begin
                  pc_q           <= pc_inc;
                  tgt_q[AW-1:DW] <= mem_rdata;
                  state_q        <= take_q ? S_SETTLE : S_IDLE;
                  done_q         <= !take_q;
               end
            end
            S_SETTLE: begin
               if (op_q == OP_CALL || op_q == OP_RST) begin
                  state_q <= S_PUSH_HI;
               end else begin
                  pc_q    <= tgt_q;
                  state_q <= S_IDLE;
                  done_q  <= 1'b1;
               end
            end
            S_PUSH_HI: begin
               if (mem_ready) begin
                  sp_q    <= sp_dec;
                  state_q <= S_PUSH_LO;
               end
            end
            S_PUSH_LO: begin
               if (mem_ready) begin
                  sp_q    <= sp_dec;
                  pc_q    <= tgt_q;
                  state_q <= S_IDLE;
                  done_q  <= 1'b1;
               end
            end
            S_TEST: begin
               state_q <= take_q ? S_POP_LO : S_IDLE;
               done_q  <= !take_q;
            end
            S_POP_LO: begin
               if (mem_ready) begin
                  tgt_q[DW-1:0] <= mem_rdata;
                  sp_q          <= sp_inc;
                  state_q       <= S_POP_HI;
               end
            end
            S_POP_HI: begin
               if (mem_ready) begin
                  tgt_q[AW-1:DW] <= mem_rdata;
                  sp_q           <= sp_inc;
                  state_q        <= S_TAIL;
               end
            end
            S_TAIL: begin
               pc_q    <= tgt_q;
               state_q <= S_IDLE;
               done_q  <= 1'b1;
               ie_q    <= (op_q == OP_RETI);
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      case (state_q)
         S_IMM_LO, S_IMM_HI: begin
            mem_req  = 1'b1;
            mem_addr = pc_q;
         end
         S_PUSH_HI: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = sp_dec;
            mem_wdata = pc_q[AW-1:DW];
         end
         S_PUSH_LO: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = sp_dec;
            mem_wdata = pc_q[DW-1:0];
         end
         S_POP_LO, S_POP_HI: begin
            mem_req  = 1'b1;
            mem_addr = sp_q;
         end
         default: ;
      endcase
   end

   assign busy     = (state_q != S_IDLE);
   assign done     = done_q;
   assign ie_pulse = ie_q;
   assign pc_out   = pc_q;
   assign sp_out   = sp_q;

endmodule

// File: rtl/xfer_seq_chk.sv
module xfer_seq_chk #(
   parameter int DW = 8,
   localparam int AW = 2 * DW
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          done,
   input logic          ie_pulse,
   input logic          mem_req,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic [DW-1:0] mem_wdata,
   input logic          mem_ready
);

   // R9: a stalled request keeps its address, direction and data
   a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

   // R11: completion is reported only when idle
   a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R11: every end of a busy stretch is followed by completion
   a_r11_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R6: the interrupt-enable pulse only accompanies completion
   a_r6_ie_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      ie_pulse |-> done);

   // R4: stack writes only happen inside a sequence
   a_r4_write_in_seq: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> busy);

endmodule

bind xfer_seq xfer_seq_chk #(.DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .done      (done),
   .ie_pulse  (ie_pulse),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_ready (mem_ready)
);

// File: tb/xfer_seq_bench.sv
module xfer_seq_bench;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  op = 3'd7;
   logic [2:0]  cond = 3'd0;
   logic        flag_z = 1'b0;
   logic        flag_c = 1'b0;
   logic [2:0]  rst_idx = 3'd0;
   logic [15:0] pc_in = '0, sp_in = '0, hl_in = '0;
   logic        busy, done, ie_pulse;
   logic [15:0] pc_out, sp_out;
   logic        mem_req, mem_we;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata, mem_rdata;
   logic        rdy = 1'b1;
   logic        stall_mode = 1'b0;
   logic        init_req = 1'b0;
   logic [7:0]  mem [256];

   int total = 0;
   int bad = 0;
   bit finished = 0;
   int cyc, ie_n;

   always #(CLK_PERIOD/2) clk = ~clk;

   xfer_seq u_xfer_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .cond(cond),
      .flag_z(flag_z), .flag_c(flag_c), .rst_idx(rst_idx),
      .pc_in(pc_in), .sp_in(sp_in), .hl_in(hl_in),
      .busy(busy), .done(done), .ie_pulse(ie_pulse),
      .pc_out(pc_out), .sp_out(sp_out),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(rdy)
   );

   assign mem_rdata = mem[mem_addr[7:0]];

   always @(posedge clk) begin
      if (init_req) begin
         for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
      end else if (mem_req && mem_we && rdy) begin
         mem[mem_addr[7:0]] <= mem_wdata;
      end
   end

   always @(negedge clk) rdy <= stall_mode ? ~rdy : 1'b1;

   typedef struct packed {
      logic [2:0]  op;
      logic [2:0]  cc;
      logic        z;
      logic        c;
      logic [2:0]  vec;
      logic [15:0] pc;
      logic [15:0] sp;
      logic [15:0] hl;
      logic [15:0] epc;
      logic [15:0] esp;
      logic [3:0]  ecyc;
      logic        push;
      logic [15:0] pval;
      logic        ie;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t TBL [NV] = '{
      '{3'd0,3'd0,1'b0,1'b0,3'd0,16'h0210,16'hC0F0,16'h0000,16'h4B4A,16'hC0F0,4'd3,1'b0,16'h0000,1'b0}, // R2 taken
      '{3'd0,3'd1,1'b0,1'b0,3'd0,16'h0210,16'hC0F0,16'h0000,16'h0212,16'hC0F0,4'd2,1'b0,16'h0000,1'b0}, // R1 Z set, not taken
      '{3'd0,3'd2,1'b0,1'b0,3'd0,16'h0210,16'hC0F0,16'h0000,16'h4B4A,16'hC0F0,4'd3,1'b0,16'h0000,1'b0}, // R1 Z clear, taken
      '{3'd1,3'd0,1'b0,1'b0,3'd0,16'h0320,16'hC0F0,16'h0000,16'h039B,16'hC0F0,4'd2,1'b0,16'h0000,1'b0}, // R3 forward
      '{3'd1,3'd3,1'b0,1'b1,3'd0,16'h03A0,16'hC0F0,16'h0000,16'h039B,16'hC0F0,4'd2,1'b0,16'h0000,1'b0}, // R3 backward, C set
      '{3'd1,3'd4,1'b0,1'b1,3'd0,16'h03A0,16'hC0F0,16'h0000,16'h03A1,16'hC0F0,4'd1,1'b0,16'h0000,1'b0}, // R3 C clear not taken
      '{3'd2,3'd0,1'b0,1'b0,3'd0,16'h0440,16'hC0F0,16'h0000,16'h1B1A,16'hC0EE,4'd5,1'b1,16'h0442,1'b0}, // R4 taken
      '{3'd2,3'd1,1'b0,1'b0,3'd0,16'h0440,16'hC0F0,16'h0000,16'h0442,16'hC0F0,4'd2,1'b0,16'h0000,1'b0}, // R4 not taken
      '{3'd3,3'd0,1'b0,1'b0,3'd0,16'h0500,16'hC080,16'h0000,16'hDBDA,16'hC082,4'd3,1'b0,16'h0000,1'b0}, // R5 plain
      '{3'd3,3'd1,1'b1,1'b0,3'd0,16'h0500,16'hC080,16'h0000,16'hDBDA,16'hC082,4'd4,1'b0,16'h0000,1'b0}, // R5 conditional taken
      '{3'd3,3'd4,1'b0,1'b1,3'd0,16'h0500,16'hC080,16'h0000,16'h0500,16'hC080,4'd1,1'b0,16'h0000,1'b0}, // R5 not taken
      '{3'd4,3'd2,1'b1,1'b0,3'd0,16'h0500,16'hC080,16'h0000,16'hDBDA,16'hC082,4'd3,1'b0,16'h0000,1'b1}, // R6 ignores cond
      '{3'd5,3'd0,1'b0,1'b0,3'd7,16'h0650,16'hC0F0,16'h0000,16'h0038,16'hC0EE,4'd3,1'b1,16'h0650,1'b0}, // R7
      '{3'd6,3'd0,1'b0,1'b0,3'd0,16'h0700,16'hC0F0,16'h1234,16'h1234,16'hC0F0,4'd0,1'b0,16'h0000,1'b0}, // R8
      '{3'd0,3'd5,1'b1,1'b1,3'd0,16'h0210,16'hC0F0,16'h0000,16'h0212,16'hC0F0,4'd2,1'b0,16'h0000,1'b0}, // R1 code 5 never
      '{3'd2,3'd3,1'b0,1'b1,3'd0,16'h0440,16'hC0F0,16'h0000,16'h1B1A,16'hC0EE,4'd5,1'b1,16'h0442,1'b0}  // R4 C set taken
   };

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   function automatic string tag_of(input logic [2:0] o);
      case (o)
         3'd0: return "R2";
         3'd1: return "R3";
         3'd2: return "R4";
         3'd3: return "R5";
         3'd4: return "R6";
         3'd5: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic init_mem();
      @(negedge clk);
      init_req = 1'b1;
      @(negedge clk);
      init_req = 1'b0;
   endtask

   task automatic launch(input vec_t v);
      @(negedge clk);
      op = v.op; cond = v.cc; flag_z = v.z; flag_c = v.c; rst_idx = v.vec;
      pc_in = v.pc; sp_in = v.sp; hl_in = v.hl;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      cyc = 0;
      ie_n = 0;
      for (int k = 0; k < 200; k++) begin
         if (ie_pulse) ie_n++;
         if (done) break;
         if (busy) cyc++;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      chk("R11 busy after reset", 32'(busy), 32'd0);
      chk("R11 done after reset", 32'(done), 32'd0);
      chk("R11 ie after reset", 32'(ie_pulse), 32'd0);
      chk("R11 req after reset", 32'(mem_req), 32'd0);
      rst_n = 1'b1;

      for (int n = 0; n < NV; n++) begin
         vec_t v;
         string t;
         v = TBL[n];
         t = tag_of(v.op);
         if (n == 1 || n == 2 || n == 14) t = "R1";
         init_mem();
         launch(v);
         wait_done();
         chk({t, " pc"}, 32'(pc_out), 32'(v.epc));
         chk({t, " sp"}, 32'(sp_out), 32'(v.esp));
         chk({t, " cycles"}, 32'(cyc), 32'(v.ecyc));
         chk({t, " R6 ie count"}, 32'(ie_n), 32'(v.ie));
         if (v.push) begin
            chk({t, " pushed high"}, 32'(mem[8'(v.esp + 16'd1)]), 32'(v.pval[15:8]));
            chk({t, " pushed low"}, 32'(mem[8'(v.esp)]), 32'(v.pval[7:0]));
         end else begin
            chk({t, " stack untouched"}, 32'(mem[8'(v.sp - 16'd1)]), 32'(8'(v.sp - 16'd1) ^ 8'h5A));
         end
         @(negedge clk);
         chk({t, " R11 done single pulse"}, 32'(done), 32'd0);
      end

      // R7: every restart vector
      for (int i = 0; i < 8; i++) begin
         vec_t v;
         v = TBL[12];
         v.vec = 3'(i);
         init_mem();
         launch(v);
         wait_done();
         chk("R7 vector", 32'(pc_out), 32'(i * 8));
      end

      // R9: stalls lengthen a call but leave its result intact
      init_mem();
      stall_mode = 1'b1;
      launch(TBL[6]);
      wait_done();
      stall_mode = 1'b0;
      chk("R9 stalled call pc", 32'(pc_out), 32'h1B1A);
      chk("R9 stalled call sp", 32'(sp_out), 32'hC0EE);
      chk("R9 stalled call longer", 32'(cyc > 5), 32'd1);
      chk("R9 stalled push high", 32'(mem[8'hEF]), 32'h04);
      chk("R9 stalled push low", 32'(mem[8'hEE]), 32'h42);

      // R10: a start during a call is ignored
      init_mem();
      launch(TBL[6]);
      op = 3'd6; hl_in = 16'h7777; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      chk("R10 call result kept", 32'(pc_out), 32'h1B1A);
      chk("R10 sp kept", 32'(sp_out), 32'hC0EE);
      repeat (2) @(negedge clk);
      chk("R10 no later completion", 32'(pc_out), 32'h1B1A);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog R11 actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule